// File: doc/BRIEF.md
# Write-Mask Guarded Control Register

This block holds two 64-bit registers: a hypervisor-level control register and a companion mask register that filters writes to it. Each implemented mask bit freezes the control field in the same bit position. A set mask bit keeps the old field value when the control register is written. A clear mask bit lets the written value through. The block also decides whether each system-register access is allowed. It answers every access with one of four outcomes: accepted, undefined, trapped to level 2, or trapped to level 3. Trapped outcomes also carry a syndrome class.

An access arrives on a single-cycle request port. The port carries a read/write flag, a 16-bit packed encoding, write data, and the current privilege level (0 to 3). Five configuration inputs set the environment:

- a top-level mask-enable bit
- a nested-virtualisation bit
- a host-mode bit
- a flag that says level 3 exists
- a flag that says the hypervisor level is enabled

The response appears one clock later. After level 2 writes a non-zero mask, level 2 can no longer change it. Only level 3 can rewrite the mask after that, or level 2 can write it again once level 3 has cleared it to zero.

The encoding is packed as {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]}. The three decoded encodings are:

| Register | op0 | op1 | CRn | CRm | op2 | Packed value |
|---|---|---|---|---|---|---|
| Mask | 3 | 4 | 1 | 4 | 3 | 0xE0A3 |
| Lower-level alias of the mask | 3 | 0 | 1 | 4 | 3 | 0xC0A3 |
| Control register | 3 | 4 | 1 | 0 | 3 | 0xE083 |

Top module: `guarded_ctrl_reg`

## Requirements
- R1: After reset, both registers hold zero and no response is valid. Every control field is therefore writable.
- R2: Only mask bits [12:1] are implemented. Bit 0 and bits [63:13] always read 0, and writes to them are ignored. The control register follows the same layout.
- R3: When the hypervisor level is enabled, a control-register write stores the new value on each bit [12:1] whose mask bit is 0. It keeps the old value on each bit whose mask bit is 1.
- R4: When the hypervisor level is not enabled, the mask has no effect: a control-register write stores bits [12:1] of the write data.
- R5: Every access from level 0 is undefined (outcome code 1).
- R6: An access from level 1 to the mask encoding or the control encoding traps to level 2 with syndrome 0x18 (outcome code 2) when nested virtualisation is set. Otherwise it is undefined.
- R7: A level-2 access to the mask or its alias traps to level 3 with syndrome 0x18 (outcome code 3) when level 3 exists and the top-level mask-enable bit is 0. When level 3 is absent, this trap is not taken.
- R8: A level-2 write to the mask while the mask is non-zero is undefined. A level-2 write while the mask is zero is accepted (outcome code 0).
- R9: Level 3 can always read and write the mask, whatever the mask holds.
- R10: At level 2 in host mode, the alias encoding reaches the mask, and the lock rule of R8 applies to it. The alias is undefined at level 2 without host mode, and at levels 1 and 3.
- R11: An unknown encoding is undefined. A rejected access (undefined or trapped) changes no register and returns read data 0. The syndrome is 0x18 on traps and 0 on all other outcomes.
- R12: Every request produces a response exactly one cycle later, and an idle cycle produces none. An accepted write returns read data 0. An accepted read returns the register value held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_level | input | 2 | Current privilege level, 0 to 3 |
| acc_enc | input | 16 | Packed register encoding |
| acc_wdata | input | 64 | Write data |
| cfg_top_mask_en | input | 1 | Top-level enable for mask access from level 2 |
| cfg_nested_virt | input | 1 | Nested virtualisation active |
| cfg_host_mode | input | 1 | Hypervisor runs in host mode |
| cfg_top_present | input | 1 | Level 3 exists |
| cfg_hyp_enabled | input | 1 | Hypervisor level enabled in the current state |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 2 | 0 ok, 1 undefined, 2 trap to level 2, 3 trap to level 3 |
| rsp_syndrome | output | 6 | Syndrome class on traps |
| rsp_rdata | output | 64 | Read data |

## Verification
The filtering function is exercised with several write data and mask combinations, each chosen to expose a different fault:

- An all-ones write under a zero mask shows that the reserved bits stay clear.
- A zero write under a partial mask shows that frozen fields keep their old value rather than the written one.
- A write with the hypervisor level disabled shows that the mask is bypassed.

The permission logic is swept across the four privilege levels and the configuration flags, and the outcomes are ordered to show trap precedence:

- The level-3 trap is tested while the mask is locked, to confirm it is taken ahead of the lock check.
- Lock and alias cases are tested both before and after a level-3 clear.

After each rejected write, a read confirms that no register changed.

// File: rtl/gcr_pkg.sv
// Package: shared types and encodings for the guarded control register.
// Assumes the 16-bit packed encoding {op0, op1, CRn, CRm, op2}.
package gcr_pkg;

    typedef enum logic [1:0] {
        OUT_OK      = 2'd0,
        OUT_UNDEF   = 2'd1,
        OUT_TRAP_L2 = 2'd2,
        OUT_TRAP_L3 = 2'd3
    } outcome_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_CTRL  = 2'd1,
        TGT_MASK  = 2'd2,
        TGT_ALIAS = 2'd3
    } target_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysenc_t;

    localparam int ENC_W = $bits(sysenc_t);

    localparam sysenc_t ENC_MASK  = '{op0: 2'd3, op1: 3'd4, crn: 4'd1, crm: 4'd4, op2: 3'd3};
    localparam sysenc_t ENC_ALIAS = '{op0: 2'd3, op1: 3'd0, crn: 4'd1, crm: 4'd4, op2: 3'd3};
    localparam sysenc_t ENC_CTRL  = '{op0: 2'd3, op1: 3'd4, crn: 4'd1, crm: 4'd0, op2: 3'd3};

endpackage

// File: rtl/gcr_enc_decode.sv
// Module: gcr_enc_decode
// Maps a packed encoding to one of the block's register targets.
// Assumes exact matches only; every other encoding maps to TGT_NONE.
module gcr_enc_decode
    import gcr_pkg::*;
(
    input  sysenc_t enc,
    output target_e target
);

    logic hit_ctrl;
    logic hit_mask;
    logic hit_alias;

    // Compare the encoding against each known register.
    always_comb begin
        hit_ctrl  = (enc == ENC_CTRL);
        hit_mask  = (enc == ENC_MASK);
        hit_alias = (enc == ENC_ALIAS);
    end

    // Resolve the matches into a target (the matches are mutually exclusive).
    always_comb begin
        if (hit_ctrl)       target = TGT_CTRL;
        else if (hit_mask)  target = TGT_MASK;
        else if (hit_alias) target = TGT_ALIAS;
        else                target = TGT_NONE;
    end

endmodule

// File: rtl/gcr_access_check.sv
// Module: gcr_access_check
// Combinational permission check for one access.
// Assumes the level is 0 to 3 and that mask_nonzero reflects the current mask.
module gcr_access_check
    import gcr_pkg::*;
#(
    parameter int               SYN_W      = 6,
    parameter logic [SYN_W-1:0] SYN_SYSREG = 6'h18
) (
    input  target_e          target,
    input  logic [1:0]       level,
    input  logic             is_write,
    input  logic             mask_nonzero,
    input  logic             top_mask_en,
    input  logic             nested_virt,
    input  logic             host_mode,
    input  logic             top_present,
    output outcome_e         outcome,
    output logic [SYN_W-1:0] syndrome
);

    logic top_blocks;
    logic lock_hit;

    // Conditions shared by the mask and alias paths at level 2.
    always_comb begin
        top_blocks = top_present && !top_mask_en;
        lock_hit   = is_write && mask_nonzero;
    end

    // Per-level decision tree; level-3 trap takes precedence over the lock.
    always_comb begin
        outcome = OUT_UNDEF;
        unique case (level)
            2'd0: outcome = OUT_UNDEF;
            2'd1: begin
                if (target == TGT_CTRL || target == TGT_MASK)
                    outcome = nested_virt ? OUT_TRAP_L2 : OUT_UNDEF;
                else
                    outcome = OUT_UNDEF;
            end
            2'd2: begin
                unique case (target)
                    TGT_CTRL: outcome = OUT_OK;
                    TGT_MASK: begin
                        if (top_blocks)    outcome = OUT_TRAP_L3;
                        else if (lock_hit) outcome = OUT_UNDEF;
                        else               outcome = OUT_OK;
                    end
                    TGT_ALIAS: begin
                        if (top_blocks)     outcome = OUT_TRAP_L3;
                        else if (!host_mode) outcome = OUT_UNDEF;
                        else if (lock_hit)  outcome = OUT_UNDEF;
                        else                outcome = OUT_OK;
                    end
                    default: outcome = OUT_UNDEF;
                endcase
            end
            default: begin
                if (target == TGT_CTRL || target == TGT_MASK)
                    outcome = OUT_OK;
                else
                    outcome = OUT_UNDEF;
            end
        endcase
    end

    // Syndrome class accompanies traps only.
    always_comb begin
        if (outcome == OUT_TRAP_L2 || outcome == OUT_TRAP_L3)
            syndrome = SYN_SYSREG;
        else
            syndrome = '0;
    end

endmodule

// File: rtl/gcr_guard_regs.sv
// Module: gcr_guard_regs
// Holds the mask and the controlled register; applies the write filter.
// Assumes at most one of wr_ctrl / wr_mask is set per cycle.
// Bits outside [GUARD_HI:GUARD_LO] are tied to zero.
module gcr_guard_regs #(
    parameter int DATA_W   = 64,
    parameter int GUARD_LO = 1,
    parameter int GUARD_HI = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_mask,
    input  logic              hyp_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] ctrl_q
);

    logic [DATA_W-1:0] mask_next;
    logic [DATA_W-1:0] ctrl_next;

    // One slice per bit: a guarded flop pair or a reserved constant.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b >= GUARD_LO && b <= GUARD_HI) begin : g_guard
            logic m_bit;
            logic c_bit;

            // Next mask bit: take write data on a mask write.
            always_comb begin
                mask_next[b] = wr_mask ? wdata[b] : m_bit;
            end

            // Next control bit: a frozen field keeps its value while the mask applies.
            always_comb begin
                if (wr_ctrl && !(hyp_en && m_bit))
                    ctrl_next[b] = wdata[b];
                else
                    ctrl_next[b] = c_bit;
            end

            // Storage for both bits with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    m_bit <= 1'b0;
                    c_bit <= 1'b0;
                end else begin
                    m_bit <= mask_next[b];
                    c_bit <= ctrl_next[b];
                end
            end

            assign mask_q[b] = m_bit;
            assign ctrl_q[b] = c_bit;
        end else begin : g_rsvd
            assign mask_next[b] = 1'b0;
            assign ctrl_next[b] = 1'b0;
            assign mask_q[b]    = 1'b0;
            assign ctrl_q[b]    = 1'b0;
        end
    end

endmodule

// File: rtl/guarded_ctrl_reg.sv
// Module: guarded_ctrl_reg (top)
// Write-mask guarded control register with access-permission checking.
// One access per cycle; the response is registered and valid one cycle later.
// Assumes the configuration inputs are stable around an access.
module guarded_ctrl_reg
    import gcr_pkg::*;
#(
    parameter int               DATA_W     = 64,
    parameter int               GUARD_LO   = 1,
    parameter int               GUARD_HI   = 12,
    parameter int               SYN_W      = 6,
    parameter logic [SYN_W-1:0] SYN_SYSREG = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_level,
    input  logic [ENC_W-1:0]  acc_enc,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              cfg_top_mask_en,
    input  logic              cfg_nested_virt,
    input  logic              cfg_host_mode,
    input  logic              cfg_top_present,
    input  logic              cfg_hyp_enabled,
    output logic              rsp_valid,
    output logic [1:0]        rsp_outcome,
    output logic [SYN_W-1:0]  rsp_syndrome,
    output logic [DATA_W-1:0] rsp_rdata
);

    target_e           target;
    outcome_e          outcome;
    logic [SYN_W-1:0]  syndrome;
    logic [DATA_W-1:0] mask_val;
    logic [DATA_W-1:0] ctrl_val;
    logic              accepted;
    logic              wr_ctrl;
    logic              wr_mask;
    logic [DATA_W-1:0] rdata_next;

    gcr_enc_decode u_dec (
        .enc    (sysenc_t'(acc_enc)),
        .target (target)
    );

    gcr_access_check #(
        .SYN_W      (SYN_W),
        .SYN_SYSREG (SYN_SYSREG)
    ) u_chk (
        .target       (target),
        .level        (acc_level),
        .is_write     (acc_write),
        .mask_nonzero (|mask_val),
        .top_mask_en  (cfg_top_mask_en),
        .nested_virt  (cfg_nested_virt),
        .host_mode    (cfg_host_mode),
        .top_present  (cfg_top_present),
        .outcome      (outcome),
        .syndrome     (syndrome)
    );

    // Turn an accepted access into register write strobes.
    always_comb begin
        accepted = acc_valid && (outcome == OUT_OK);
        wr_ctrl  = accepted && acc_write && (target == TGT_CTRL);
        wr_mask  = accepted && acc_write &&
                   (target == TGT_MASK || target == TGT_ALIAS);
    end

    gcr_guard_regs #(
        .DATA_W   (DATA_W),
        .GUARD_LO (GUARD_LO),
        .GUARD_HI (GUARD_HI)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_mask (wr_mask),
        .hyp_en  (cfg_hyp_enabled),
        .wdata   (acc_wdata),
        .mask_q  (mask_val),
        .ctrl_q  (ctrl_val)
    );

    // Read data for accepted reads only; zero for writes and rejections.
    always_comb begin
        rdata_next = '0;
        if (accepted && !acc_write)
            rdata_next = (target == TGT_CTRL) ? ctrl_val : mask_val;
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_outcome  <= OUT_OK;
            rsp_syndrome <= '0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid    <= acc_valid;
            rsp_outcome  <= acc_valid ? outcome  : OUT_OK;
            rsp_syndrome <= acc_valid ? syndrome : '0;
            rsp_rdata    <= acc_valid ? rdata_next : '0;
        end
    end

endmodule

// File: rtl/guarded_ctrl_reg_chk.sv
// Module: guarded_ctrl_reg_chk
// Temporal checks on the guarded control register, bound to the top module.
module guarded_ctrl_reg_chk
    import gcr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int GUARD_LO = 1,
    parameter int GUARD_HI = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [1:0]        acc_level,
    input logic [ENC_W-1:0]  acc_enc,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              cfg_top_mask_en,
    input logic              cfg_top_present,
    input logic              cfg_hyp_enabled,
    input logic              rsp_valid,
    input logic [1:0]        rsp_outcome,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [DATA_W-1:0] mask_val,
    input logic [DATA_W-1:0] ctrl_val
);

    localparam logic [DATA_W-1:0] GUARD_M =
        ({DATA_W{1'b1}} << GUARD_LO) & ~({DATA_W{1'b1}} << (GUARD_HI + 1));

    // R12
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    // R12
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    // R5
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_level == 2'd0) |=> (rsp_outcome == 2'd1));

    // R2
    mask_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_val & ~GUARD_M) == '0);

    // R11
    reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome != 2'd0) |-> (rsp_rdata == '0));

    // R11
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome != 2'd0) |->
        (mask_val == $past(mask_val) && ctrl_val == $past(ctrl_val)));

    // R8
    lock_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_level == 2'd2 && acc_enc == ENC_MASK &&
         !(cfg_top_present && !cfg_top_mask_en) && mask_val != '0)
        |=> (rsp_outcome == 2'd1));

    // R3
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hyp_enabled |=> (((ctrl_val ^ $past(ctrl_val)) & $past(mask_val)) == '0));

    // R9
    top_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_level == 2'd3 && acc_enc == ENC_MASK)
        |=> (rsp_outcome == 2'd0 && mask_val == ($past(acc_wdata) & GUARD_M)));

endmodule

bind guarded_ctrl_reg guarded_ctrl_reg_chk #(
    .DATA_W   (DATA_W),
    .GUARD_LO (GUARD_LO),
    .GUARD_HI (GUARD_HI)
) u_gcr_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_write       (acc_write),
    .acc_level       (acc_level),
    .acc_enc         (acc_enc),
    .acc_wdata       (acc_wdata),
    .cfg_top_mask_en (cfg_top_mask_en),
    .cfg_top_present (cfg_top_present),
    .cfg_hyp_enabled (cfg_hyp_enabled),
    .rsp_valid       (rsp_valid),
    .rsp_outcome     (rsp_outcome),
    .rsp_rdata       (rsp_rdata),
    .mask_val        (mask_val),
    .ctrl_val        (ctrl_val)
);

// File: tb/guarded_ctrl_reg_tb.sv
// Bench: behavioural reference model compared against every response.
module guarded_ctrl_reg_tb;

    localparam logic [15:0] E_MASK  = 16'hE0A3;
    localparam logic [15:0] E_ALIAS = 16'hC0A3;
    localparam logic [15:0] E_CTRL  = 16'hE083;
    localparam logic [15:0] E_BAD   = 16'h1234;
    localparam logic [63:0] GUARD   = 64'h0000_0000_0000_1FFE;
    localparam int OK = 0, UND = 1, T2 = 2, T3 = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_level = 2'd0;
    logic [15:0] acc_enc = '0;
    logic [63:0] acc_wdata = '0;
    logic        cfg_top_mask_en = 1'b1;
    logic        cfg_nested_virt = 1'b0;
    logic        cfg_host_mode = 1'b0;
    logic        cfg_top_present = 1'b1;
    logic        cfg_hyp_enabled = 1'b1;
    logic        rsp_valid;
    logic [1:0]  rsp_outcome;
    logic [5:0]  rsp_syndrome;
    logic [63:0] rsp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] m_mask = '0;
    logic [63:0] m_ctrl = '0;

    guarded_ctrl_reg u_dut (
        .clk (clk), .rst_n (rst_n),
        .acc_valid (acc_valid), .acc_write (acc_write),
        .acc_level (acc_level), .acc_enc (acc_enc), .acc_wdata (acc_wdata),
        .cfg_top_mask_en (cfg_top_mask_en), .cfg_nested_virt (cfg_nested_virt),
        .cfg_host_mode (cfg_host_mode), .cfg_top_present (cfg_top_present),
        .cfg_hyp_enabled (cfg_hyp_enabled),
        .rsp_valid (rsp_valid), .rsp_outcome (rsp_outcome),
        .rsp_syndrome (rsp_syndrome), .rsp_rdata (rsp_rdata)
    );

    always #5 clk = ~clk;

    task automatic note(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference model: decide outcome and read data, update model state.
    task automatic model(input int lvl, input bit wr, input logic [15:0] enc,
                         input logic [63:0] wd, output int oc, output logic [63:0] rd);
        bit block3 = cfg_top_present && !cfg_top_mask_en;
        bit locked = (m_mask != 0) && wr;
        oc = UND;
        if (lvl == 1) begin
            if (enc == E_CTRL || enc == E_MASK) oc = cfg_nested_virt ? T2 : UND;
        end else if (lvl == 2) begin
            if (enc == E_CTRL) oc = OK;
            else if (enc == E_MASK) oc = block3 ? T3 : (locked ? UND : OK);
            else if (enc == E_ALIAS)
                oc = block3 ? T3 : ((!cfg_host_mode || locked) ? UND : OK);
        end else if (lvl == 3) begin
            if (enc == E_CTRL || enc == E_MASK) oc = OK;
        end
        rd = '0;
        if (oc == OK) begin
            if (wr) begin
                if (enc == E_CTRL)
                    m_ctrl = cfg_hyp_enabled ? (((m_ctrl & m_mask) | (wd & ~m_mask)) & GUARD)
                                             : (wd & GUARD);
                else
                    m_mask = wd & GUARD;
            end else begin
                rd = (enc == E_CTRL) ? m_ctrl : m_mask;
            end
        end
    endtask

    task automatic access(input int lvl, input bit wr, input logic [15:0] enc,
                          input logic [63:0] wd, input string req);
        int oc;
        logic [63:0] rd;
        model(lvl, wr, enc, wd, oc, rd);
        acc_valid = 1'b1; acc_write = wr; acc_level = lvl[1:0];
        acc_enc = enc; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        note(req, "valid", {63'd0, rsp_valid}, 64'd1);
        note(req, "outcome", {62'd0, rsp_outcome}, oc);
        note(req, "syndrome", {58'd0, rsp_syndrome}, (oc >= T2) ? 64'h18 : 64'h0);
        note(req, "rdata", rsp_rdata, rd);
    endtask

    task automatic idle(input string req);
        acc_valid = 1'b0;
        @(negedge clk);
        note(req, "idle valid", {63'd0, rsp_valid}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle("R1");
        access(3, 0, E_CTRL, 0, "R1");
        access(3, 0, E_MASK, 0, "R1");
        // R3 zero mask, all ones: R2 reserved bits stay clear
        access(2, 1, E_CTRL, '1, "R3");
        access(2, 0, E_CTRL, 0, "R2");
        // R8 first write while zero; R2 mask reserved bits dropped
        access(2, 1, E_MASK, 64'hFFFF_FFFF_FFFF_FF0B, "R8");
        access(2, 0, E_MASK, 0, "R2");
        // R3 frozen fields keep old value
        access(2, 1, E_CTRL, 0, "R3");
        access(2, 0, E_CTRL, 0, "R3");
        access(2, 1, E_CTRL, 64'h0000_0000_0000_00F4, "R3");
        access(3, 0, E_CTRL, 0, "R3");
        // R8 lock, R11 hold
        access(2, 1, E_MASK, 0, "R8");
        access(2, 0, E_MASK, 0, "R11");
        // R7 trap to level 3 even while locked
        cfg_top_mask_en = 1'b0;
        access(2, 1, E_MASK, 0, "R7");
        access(2, 0, E_ALIAS, 0, "R7");
        access(2, 0, E_CTRL, 0, "R7");
        cfg_top_present = 1'b0;
        access(2, 0, E_MASK, 0, "R7");
        cfg_top_present = 1'b1; cfg_top_mask_en = 1'b1;
        // R10 alias
        cfg_host_mode = 1'b1;
        access(2, 0, E_ALIAS, 0, "R10");
        access(2, 1, E_ALIAS, 0, "R10");
        cfg_host_mode = 1'b0;
        access(2, 0, E_ALIAS, 0, "R10");
        access(1, 0, E_ALIAS, 0, "R10");
        access(3, 0, E_ALIAS, 0, "R10");
        // R9 level 3 rewrites a locked mask, then clears it
        access(3, 1, E_MASK, 64'h0000_0000_0000_0FF0, "R9");
        access(3, 0, E_MASK, 0, "R9");
        access(3, 1, E_MASK, 0, "R9");
        cfg_host_mode = 1'b1;
        access(2, 1, E_ALIAS, 64'h0000_0000_0000_1006, "R10");
        access(2, 0, E_ALIAS, 0, "R10");
        cfg_host_mode = 1'b0;
        // R4 hypervisor disabled: mask bypassed
        cfg_hyp_enabled = 1'b0;
        access(2, 1, E_CTRL, 64'h0000_0000_0000_1556, "R4");
        access(2, 0, E_CTRL, 0, "R4");
        cfg_hyp_enabled = 1'b1;
        // R5 level 0
        access(0, 0, E_MASK, 0, "R5");
        access(0, 1, E_CTRL, 0, "R5");
        // R6 level 1
        access(1, 1, E_CTRL, '1, "R6");
        cfg_nested_virt = 1'b1;
        access(1, 1, E_MASK, 0, "R6");
        access(1, 0, E_CTRL, 0, "R6");
        cfg_nested_virt = 1'b0;
        access(3, 0, E_CTRL, 0, "R11");
        // R11 unknown encoding
        access(3, 1, E_BAD, '1, "R11");
        access(3, 0, E_MASK, 0, "R11");
        // R12 idle cycles and back-to-back
        idle("R12");
        access(3, 0, E_CTRL, 0, "R12");
        access(3, 1, E_CTRL, 0, "R12");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule